// File: doc/BRIEF.md
# Page-Granular SRAM Write Guard

This block sits between a bus master and a 64-Kbyte SRAM. It treats the SRAM as 64 pages of 1 Kbyte each and stops writes to any page that software has locked. A 64-bit lock mask is held as two 32-bit registers:

- the low register covers pages 0 to 31;
- the high register covers pages 32 to 63.

Software can only add locks. A lock bit is set by writing 1 to it. Only a reset of the block clears it.

Every access request is classified in a single cycle. The block then registers the access toward the memory.

- **Reads** always pass through.
- **Writes to an unlocked page** pass through with their address, byte enables and data.
- **Writes to a locked page** are dropped. No memory enable or write strobe is issued for them. Instead, a violation pulse is raised in the cycle the write would have reached the memory.

The asynchronous active-low reset is released through a two-stage synchronizer.

Top module: `page_wr_guard`

## Requirements
- R1: After reset every lock bit reads 0. `mem_en_o`, `mem_we_o` and `viol_o` are all 0 while no access has been issued.
- R2: Lock bit n of register 0 (`cfg_set_sel`=0 / `cfg_rd_sel`=0) guards page n. Bit n of register 1 guards page n+32. The page of an access is `req_addr[15:10]`.
- R3: A configuration write ORs `cfg_set_data` into the selected register. Writing 0 to a bit leaves it unchanged, so a set lock bit never clears before reset.
- R4: A write request (`req_valid`=1, `req_write`=1) to a locked page gives, in the next cycle, `viol_o`=1 with `mem_en_o`=0 and `mem_we_o`=0.
- R5: A write request to an unlocked page gives, in the next cycle, `mem_en_o`=1 and `mem_we_o`=1 with `viol_o`=0.
- R6: A read request (`req_write`=0) gives, in the next cycle, `mem_en_o`=1, `mem_we_o`=0 and `viol_o`=0 whatever the lock state.
- R7: Exactly one cycle after any request that passes, `mem_addr_o`, `mem_be_o` and `mem_wdata_o` equal that request's address, byte enables and data. A cycle without a request is followed by a cycle with `mem_en_o`=0 and `viol_o`=0.
- R8: A lock set in the same cycle as a write request applies only to later requests. The simultaneous write uses the mask as it was before the set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_set_en | input | 1 | Lock register write strobe |
| cfg_set_sel | input | 1 | Lock register select for writes (0 low, 1 high) |
| cfg_set_data | input | 32 | Bits to set in the selected lock register |
| cfg_rd_sel | input | 1 | Lock register select for readback |
| cfg_rd_data | output | 32 | Selected lock register contents |
| req_valid | input | 1 | Access request |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | 16 | Byte address relative to the SRAM base |
| req_be | input | 4 | Byte enables |
| req_wdata | input | 32 | Write data |
| mem_en_o | output | 1 | Memory access enable |
| mem_we_o | output | 1 | Gated memory write strobe |
| mem_addr_o | output | 16 | Registered address to memory |
| mem_be_o | output | 4 | Registered byte enables to memory |
| mem_wdata_o | output | 32 | Registered write data to memory |
| viol_o | output | 1 | One-cycle pulse per dropped write |

## Verification
The bench writes to the first and last word of all 64 pages, both before and after locks are set. The locks are set on pages 0, 31, 32 and 63, so the bit 31/32 edge between the two registers and the 1-Kbyte page edges are covered. A decoder that takes the wrong address bits, or that swaps the two registers, would block the wrong page at one of these points.

Zero writes are issued after the locks are set. A design that assigns rather than ORs the incoming bits would drop the locks here.

A lock set in the same cycle as a write to that page exposes a design that bypasses the lock register into the decode. Reads to locked pages expose a guard that also blocks reads. A reset in mid-run shows that the locks are cleared.

// File: rtl/pwp_pkg.sv
package pwp_pkg;

  // Classification of one access request.
  typedef enum logic [1:0] {
    ACC_IDLE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2,
    ACC_BLOCK = 2'd3
  } acc_kind_t;

endpackage

// File: rtl/pwp_mask_regs.sv
module pwp_mask_regs #(
  parameter  int PAGE_CNT = 64,
  parameter  int REG_W    = 32,
  localparam int REG_CNT  = PAGE_CNT / REG_W,
  localparam int SEL_W    = (REG_CNT > 1) ? $clog2(REG_CNT) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                set_en,
  input  logic [SEL_W-1:0]    set_sel,
  input  logic [REG_W-1:0]    set_data,
  input  logic [SEL_W-1:0]    rd_sel,
  output logic [REG_W-1:0]    rd_data,
  output logic [PAGE_CNT-1:0] mask
);

  logic [REG_CNT-1:0][REG_W-1:0] regs;

  for (genvar g = 0; g < REG_CNT; g++) begin : g_reg
    logic             hit;
    logic [REG_W-1:0] nxt;
    logic [REG_W-1:0] q;

    // Set-only update: incoming ones are ORed in.
    always_comb begin
      hit = set_en && (set_sel == SEL_W'(g));
      nxt = q | set_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q <= '0;
      end else if (hit) begin
        q <= nxt;
      end
    end

    assign regs[g] = q;
  end

  assign mask    = regs;
  assign rd_data = regs[rd_sel];

endmodule

// File: rtl/pwp_page_check.sv
module pwp_page_check
  import pwp_pkg::*;
#(
  parameter  int PAGE_CNT = 64,
  localparam int IDX_W    = $clog2(PAGE_CNT)
) (
  input  logic                req_valid,
  input  logic                req_write,
  input  logic [IDX_W-1:0]    page_idx,
  input  logic [PAGE_CNT-1:0] mask,
  output acc_kind_t           kind
);

  logic locked;

  always_comb begin
    locked = mask[page_idx];
    if (!req_valid) begin
      kind = ACC_IDLE;
    end else if (!req_write) begin
      kind = ACC_READ;
    end else if (locked) begin
      kind = ACC_BLOCK;
    end else begin
      kind = ACC_WRITE;
    end
  end

endmodule

// File: rtl/pwp_out_stage.sv
module pwp_out_stage
  import pwp_pkg::*;
#(
  parameter  int ADDR_W = 16,
  parameter  int DATA_W = 32,
  localparam int BE_W   = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  acc_kind_t         kind,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BE_W-1:0]   be,
  input  logic [DATA_W-1:0] wdata,
  output logic              mem_en,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [BE_W-1:0]   mem_be,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              viol
);

  acc_kind_t         kind_q;
  logic              cap_en;
  logic [ADDR_W-1:0] addr_q;
  logic [BE_W-1:0]   be_q;
  logic [DATA_W-1:0] data_q;

  // Payload registers load only when an access actually passes.
  always_comb begin
    cap_en = (kind == ACC_READ) || (kind == ACC_WRITE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q <= ACC_IDLE;
    end else begin
      kind_q <= kind;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      be_q   <= '0;
      data_q <= '0;
    end else if (cap_en) begin
      addr_q <= addr;
      be_q   <= be;
      data_q <= wdata;
    end
  end

  always_comb begin
    mem_en    = (kind_q == ACC_READ) || (kind_q == ACC_WRITE);
    mem_we    = (kind_q == ACC_WRITE);
    viol      = (kind_q == ACC_BLOCK);
    mem_addr  = addr_q;
    mem_be    = be_q;
    mem_wdata = data_q;
  end

endmodule

// File: rtl/page_wr_guard.sv
module page_wr_guard
  import pwp_pkg::*;
#(
  parameter  int PAGE_CNT   = 64,
  parameter  int PAGE_BYTES = 1024,
  parameter  int REG_W      = 32,
  parameter  int ADDR_W     = 16,
  parameter  int DATA_W     = 32,
  localparam int OFF_W      = $clog2(PAGE_BYTES),
  localparam int IDX_W      = $clog2(PAGE_CNT),
  localparam int REG_CNT    = PAGE_CNT / REG_W,
  localparam int SEL_W      = (REG_CNT > 1) ? $clog2(REG_CNT) : 1,
  localparam int BE_W       = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_set_en,
  input  logic [SEL_W-1:0]  cfg_set_sel,
  input  logic [REG_W-1:0]  cfg_set_data,
  input  logic [SEL_W-1:0]  cfg_rd_sel,
  output logic [REG_W-1:0]  cfg_rd_data,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [BE_W-1:0]   req_be,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              mem_en_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [BE_W-1:0]   mem_be_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic              viol_o
);

  logic [1:0]          rst_pipe;
  logic                rst_sync_n;
  logic [PAGE_CNT-1:0] lock_mask;
  logic [IDX_W-1:0]    page_idx;
  acc_kind_t           acc_kind;

  // Assert asynchronously, release after two clock edges.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe[1];

  assign page_idx = req_addr[OFF_W +: IDX_W];

  pwp_mask_regs #(.PAGE_CNT(PAGE_CNT), .REG_W(REG_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .set_en   (cfg_set_en),
    .set_sel  (cfg_set_sel),
    .set_data (cfg_set_data),
    .rd_sel   (cfg_rd_sel),
    .rd_data  (cfg_rd_data),
    .mask     (lock_mask)
  );

  pwp_page_check #(.PAGE_CNT(PAGE_CNT)) u_check (
    .req_valid (req_valid),
    .req_write (req_write),
    .page_idx  (page_idx),
    .mask      (lock_mask),
    .kind      (acc_kind)
  );

  pwp_out_stage #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .kind      (acc_kind),
    .addr      (req_addr),
    .be        (req_be),
    .wdata     (req_wdata),
    .mem_en    (mem_en_o),
    .mem_we    (mem_we_o),
    .mem_addr  (mem_addr_o),
    .mem_be    (mem_be_o),
    .mem_wdata (mem_wdata_o),
    .viol      (viol_o)
  );

endmodule

// File: rtl/pwp_guard_checker.sv
module pwp_guard_checker #(
  parameter  int PAGE_CNT = 64,
  localparam int IDX_W    = $clog2(PAGE_CNT)
) (
  input logic                clk,
  input logic                rst_n,
  input logic                req_valid,
  input logic                req_write,
  input logic [IDX_W-1:0]    page_idx,
  input logic [PAGE_CNT-1:0] mask,
  input logic                mem_en,
  input logic                mem_we,
  input logic                viol
);

  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((mask & $past(mask)) == $past(mask))); // R3

  AST_LOCKED_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && mask[page_idx]) |=> (viol && !mem_we && !mem_en)); // R4

  AST_OPEN_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && !mask[page_idx]) |=> (mem_we && mem_en && !viol)); // R5

  AST_READ_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> (mem_en && !mem_we && !viol)); // R6

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!mem_en && !viol)); // R7

endmodule

bind page_wr_guard pwp_guard_checker #(.PAGE_CNT(PAGE_CNT)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .req_valid (req_valid),
  .req_write (req_write),
  .page_idx  (page_idx),
  .mask      (lock_mask),
  .mem_en    (mem_en_o),
  .mem_we    (mem_we_o),
  .viol      (viol_o)
);

// File: tb/page_wr_guard_bench.sv
module page_wr_guard_bench;

  localparam int CLK_PERIOD = 10;
  localparam int PAGES      = 64;
  localparam int PG_BYTES   = 1024;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_set_en, cfg_set_sel, cfg_rd_sel;
  logic [31:0] cfg_set_data, cfg_rd_data;
  logic        req_valid, req_write;
  logic [15:0] req_addr, mem_addr_o;
  logic [3:0]  req_be, mem_be_o;
  logic [31:0] req_wdata, mem_wdata_o;
  logic        mem_en_o, mem_we_o, viol_o;

  int checks = 0;
  int errors = 0;
  logic [63:0] model;

  always #(CLK_PERIOD / 2) clk = ~clk;

  page_wr_guard u_page_wr_guard (
    .clk(clk), .rst_n(rst_n),
    .cfg_set_en(cfg_set_en), .cfg_set_sel(cfg_set_sel), .cfg_set_data(cfg_set_data),
    .cfg_rd_sel(cfg_rd_sel), .cfg_rd_data(cfg_rd_data),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_be(req_be), .req_wdata(req_wdata),
    .mem_en_o(mem_en_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_be_o(mem_be_o), .mem_wdata_o(mem_wdata_o), .viol_o(viol_o)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic set_lock(input logic sel, input logic [31:0] d);
    @(negedge clk);
    cfg_set_en = 1'b1; cfg_set_sel = sel; cfg_set_data = d;
    @(negedge clk);
    cfg_set_en = 1'b0;
    model[sel*32 +: 32] = model[sel*32 +: 32] | d;
  endtask

  task automatic check_regs(input string tag);
    cfg_rd_sel = 1'b0; #1;
    chk({tag, " low reg"}, 64'(cfg_rd_data), 64'(model[31:0]));
    cfg_rd_sel = 1'b1; #1;
    chk({tag, " high reg"}, 64'(cfg_rd_data), 64'(model[63:32]));
  endtask

  // Drive at a falling edge; the result is registered at the next rising
  // edge and sampled at the falling edge after it.
  task automatic access(input logic [15:0] a, input logic w, input logic [3:0] be,
                        input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_be = be; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic sweep_writes(input string phase);
    for (int p = 0; p < PAGES; p++) begin
      for (int k = 0; k < 2; k++) begin
        logic [15:0] a;
        logic [31:0] d;
        logic        blk;
        a   = 16'(p * PG_BYTES + k * (PG_BYTES - 4));
        d   = 32'(p * 7919 + k * 13 + 32'h1000);
        blk = model[p];
        access(a, 1'b1, 4'(p % 16), d);
        if (blk) begin
          chk({phase, " R4 viol"}, 64'(viol_o), 64'd1);
          chk({phase, " R4 no strobe"}, 64'({mem_en_o, mem_we_o}), 64'd0);
        end else begin
          chk({phase, " R5 strobe"}, 64'({mem_en_o, mem_we_o, viol_o}), 64'b110);
          chk({phase, " R7 addr"}, 64'(mem_addr_o), 64'(a));
          chk({phase, " R7 data"}, 64'(mem_wdata_o), 64'(d));
          chk({phase, " R7 be"}, 64'(mem_be_o), 64'(p % 16));
        end
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_set_en = 1'b0; cfg_set_sel = 1'b0; cfg_set_data = '0;
    cfg_rd_sel = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0;
    req_be = '0; req_wdata = '0; model = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    check_regs("R1 reset");
    chk("R1 idle outputs", 64'({mem_en_o, mem_we_o, viol_o}), 64'd0);

    // R5, R7: all pages open
    sweep_writes("open");

    // R7: idle cycle after traffic
    @(negedge clk);
    chk("R7 idle quiet", 64'({mem_en_o, viol_o}), 64'd0);

    // R2, R3: set locks at register edges, then write zeros
    set_lock(1'b0, 32'h8000_0001);
    set_lock(1'b1, 32'h0000_0081);
    set_lock(1'b0, 32'h0001_0000);
    set_lock(1'b1, 32'h8000_0000);
    check_regs("R2 mapping");
    set_lock(1'b0, 32'h0);
    set_lock(1'b1, 32'h0);
    check_regs("R3 zero write keeps locks");
    set_lock(1'b0, 32'h0000_0100);
    check_regs("R3 OR accumulate");

    // R2, R4, R5: full sweep with locks
    sweep_writes("locked");

    // R6: reads pass on every page
    for (int p = 0; p < PAGES; p++) begin
      access(16'(p * PG_BYTES + 8), 1'b0, 4'hF, 32'h0);
      chk("R6 read pass", 64'({mem_en_o, mem_we_o, viol_o}), 64'b100);
      chk("R6 read addr", 64'(mem_addr_o), 64'(p * PG_BYTES + 8));
    end

    // R8: lock set in the same cycle as a write to that page (page 40)
    @(negedge clk);
    cfg_set_en = 1'b1; cfg_set_sel = 1'b1; cfg_set_data = 32'h0000_0100;
    req_valid = 1'b1; req_write = 1'b1; req_addr = 16'(40 * PG_BYTES); req_be = 4'hF;
    req_wdata = 32'hCAFE_0040;
    @(negedge clk);
    cfg_set_en = 1'b0; req_valid = 1'b0; req_write = 1'b0;
    model[40] = 1'b1;
    chk("R8 same-cycle write uses old mask", 64'({mem_we_o, viol_o}), 64'b10);
    access(16'(40 * PG_BYTES + 4), 1'b1, 4'hF, 32'h1);
    chk("R8 later write blocked", 64'({mem_we_o, viol_o}), 64'b01);

    // R1: reset clears all locks
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    model = '0;
    repeat (4) @(negedge clk);
    check_regs("R1 reset clears");
    access(16'h0000, 1'b1, 4'hF, 32'h5);
    chk("R1 page 0 open after reset", 64'({mem_we_o, viol_o}), 64'b10);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule